// File: doc/BRIEF.md
# UART RS-485 Transmit Direction Control

This block steers the driver-enable (RTS) pin of a half-duplex line transceiver next to a UART transmitter, so that software never has to toggle it. It watches two status inputs from the transmitter: whether the transmit queue holds data and whether the shift register is shifting. It switches the line to the transmit direction on the first clock edge that shows any pending character. It switches the line back to receive only after the shift register has been empty for three full bit periods. That hold gives the final stop bit time to get through the transceiver.

The bit period is derived inside the block from the baud divisor and the oversampling selection: divisor times 16 clocks, or divisor times 13 clocks. The lead time before transmission and the release hold are both fixed. A small mode register gives software two controls: an enable bit and a polarity bit that chooses the active level. Writes to the mode register are applied only when the transmitter is idle. While the enable bit is clear, the pin simply follows the ordinary modem-control RTS value.

Top module: `rs485_dir_top`

## Requirements
- R1: After reset the mode register reads 0x00 and `rtsOut` equals `modemRts`.
- R2: With the enable bit clear, `rtsOut` equals `modemRts` whatever the transmitter status inputs do.
- R3: With the enable bit set, `rtsOut` equals the polarity bit while transmitting and its inverse while receiving: polarity 1 gives active-high, polarity 0 gives active-low.
- R4: The transmit direction appears on the first rising edge at which `txFifoEmpty` or `txShiftEmpty` is sampled low. There is no lead delay.
- R5: In 16x mode (`overSample13` = 0), once both status inputs are high the transmit level is held for exactly 3 × 16 × `divisor` clocks. The edge that samples them high counts as the start.
- R6: In 13x mode (`overSample13` = 1), the same hold lasts exactly 3 × 13 × `divisor` clocks.
- R7: If a status input goes low again during the hold, the hold is cancelled. The output stays at the transmit level with no gap, and a later release is timed afresh from the new empty point.
- R8: With `divisor` = 0, the output returns to the receive level on the first edge that samples the transmitter empty.
- R9: A mode write made while a frame or its hold is in progress does not change the mode read-back or the output. It is applied on the edge after the block returns to idle.
- R10: The mode register is at byte offset 0x20. Bit 4 is the enable and bit 3 is the polarity; the other bits read 0. Writes to any other offset leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset |
| regWrData | input | 8 | Register write data |
| modeRdData | output | 8 | Mode register value currently in force |
| divisor | input | 16 | Baud divisor, 0 disables the bit timer |
| overSample13 | input | 1 | 1 selects 13 clocks per divisor unit, 0 selects 16 |
| txFifoEmpty | input | 1 | Transmit queue holds no data |
| txShiftEmpty | input | 1 | Transmit shift register is idle |
| modemRts | input | 1 | Ordinary modem-control RTS value |
| rtsOut | output | 1 | Transceiver direction pin |

## Verification
Frames are sent with both polarities, under 16x and 13x timing and with two divisors. The output is sampled on the clock before and on the clock of the expected release, so a hold that is one cycle short or long, or that uses the wrong multiplier, is caught. Separate patterns restart transmission part-way through the hold and use a zero divisor; these tell a cancelled hold apart from one that keeps running, and an immediate release apart from a stuck one. Mode writes to a wrong offset and writes made mid-frame show whether address decoding and deferred application work.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_HOLD} dirState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic holdStart;  // clear bit timer, start hold window
    logic holdRun;    // advance bit timer this cycle
    logic applyOk;    // transmitter idle: mode writes may land
  } dirStrobe_t;
endpackage

// File: rtl/rs485_dir_dp.sv
module rs485_dir_dp #(
  parameter int DIV_W     = 16,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int MODE_ADDR = 32,
  parameter int EN_BIT    = 4,
  parameter int POL_BIT   = 3,
  parameter int HOLD_BITS = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rs485_dir_pkg::dirStrobe_t  strobe,
  input  logic                       regWrEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          regWrData,
  input  logic [DIV_W-1:0]           divisor,
  input  logic                       overSample13,
  output logic [DATA_W-1:0]          modeReg,
  output logic                       modeEn,
  output logic                       modePol,
  output logic                       divZero,
  output logic                       holdDone
);
  localparam int PER_W  = DIV_W + 5;
  localparam int BCNT_W = $clog2(HOLD_BITS + 1);
  localparam logic [DATA_W-1:0] MODE_MASK =
    DATA_W'((1 << EN_BIT) | (1 << POL_BIT));

  logic [PER_W-1:0]  period;
  logic [PER_W-1:0]  periodM1;
  logic [PER_W-1:0]  prescale;
  logic [BCNT_W-1:0] bitCnt;
  logic              tick;
  logic [DATA_W-1:0] pendReg;
  logic              pendValid;
  logic              modeHit;

  assign period   = overSample13 ? PER_W'(divisor) * PER_W'(13)
                                 : PER_W'(divisor) * PER_W'(16);
  assign periodM1 = period - PER_W'(1);
  assign divZero  = (divisor == '0);
  assign tick     = strobe.holdRun && (prescale == periodM1);
  assign holdDone = divZero || (tick && (bitCnt == BCNT_W'(HOLD_BITS - 1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescale <= '0;
      bitCnt   <= '0;
    end else if (strobe.holdStart) begin
      prescale <= '0;
      bitCnt   <= '0;
    end else if (strobe.holdRun) begin
      if (tick) begin
        prescale <= '0;
        bitCnt   <= bitCnt + BCNT_W'(1);
      end else begin
        prescale <= prescale + PER_W'(1);
      end
    end
  end

  assign modeHit = regWrEn && (regAddr == ADDR_W'(MODE_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg   <= '0;
      pendReg   <= '0;
      pendValid <= 1'b0;
    end else if (modeHit) begin
      if (strobe.applyOk) begin
        modeReg   <= regWrData & MODE_MASK;
        pendValid <= 1'b0;
      end else begin
        pendReg   <= regWrData & MODE_MASK;
        pendValid <= 1'b1;
      end
    end else if (strobe.applyOk && pendValid) begin
      modeReg   <= pendReg;
      pendValid <= 1'b0;
    end
  end

  assign modeEn  = modeReg[EN_BIT];
  assign modePol = modeReg[POL_BIT];
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       txBusy,
  input  logic                       modeEn,
  input  logic                       divZero,
  input  logic                       holdDone,
  output rs485_dir_pkg::dirStrobe_t  strobe,
  output logic                       dirActive
);
  import rs485_dir_pkg::*;

  dirState_t state, stateNxt;

  always_comb begin
    stateNxt         = state;
    strobe.holdStart = 1'b0;
    strobe.holdRun   = 1'b0;
    strobe.applyOk   = (state == ST_IDLE) && !txBusy;
    unique case (state)
      ST_IDLE: if (txBusy && modeEn) stateNxt = ST_SEND;
      ST_SEND: begin
        if (!txBusy) begin
          if (divZero) stateNxt = ST_IDLE;
          else begin
            stateNxt         = ST_HOLD;
            strobe.holdStart = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (txBusy) stateNxt = ST_SEND;
        else begin
          strobe.holdRun = 1'b1;
          if (holdDone) stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign dirActive = (state != ST_IDLE);
endmodule

// File: rtl/rs485_dir_top.sv
module rs485_dir_top #(
  parameter int DIV_W     = 16,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int MODE_ADDR = 32,
  parameter int EN_BIT    = 4,
  parameter int POL_BIT   = 3,
  parameter int HOLD_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] modeRdData,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              overSample13,
  input  logic              txFifoEmpty,
  input  logic              txShiftEmpty,
  input  logic              modemRts,
  output logic              rtsOut
);
  rs485_dir_pkg::dirStrobe_t strobe;
  logic txBusy, modeEn, modePol, divZero, holdDone, dirActive;

  assign txBusy = !txFifoEmpty || !txShiftEmpty;

  rs485_dir_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txBusy(txBusy), .modeEn(modeEn),
    .divZero(divZero), .holdDone(holdDone), .strobe(strobe),
    .dirActive(dirActive)
  );

  rs485_dir_dp #(
    .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADDR(MODE_ADDR),
    .EN_BIT(EN_BIT), .POL_BIT(POL_BIT), .HOLD_BITS(HOLD_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .divisor(divisor),
    .overSample13(overSample13), .modeReg(modeRdData), .modeEn(modeEn),
    .modePol(modePol), .divZero(divZero), .holdDone(holdDone)
  );

  assign rtsOut = modeEn ? (dirActive ? modePol : !modePol) : modemRts;
endmodule

// File: rtl/rs485_dir_chk.sv
module rs485_dir_chk #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              txBusy,
  input logic              modeEn,
  input logic              modePol,
  input logic              rtsOut,
  input logic [DIV_W-1:0]  divisor,
  input logic [DATA_W-1:0] modeRdData
);
  // R4
  assert_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeEn && txBusy) |=> (rtsOut == modePol));

  // R5
  hold_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeEn && divisor != '0 && $past(divisor) != '0 && $past(txBusy, 2))
      |-> (rtsOut == modePol));

  // R8
  zero_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeEn && divisor == '0 && $past(divisor) == '0 && !$past(txBusy))
      |-> (rtsOut != modePol));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |=> $stable(modeRdData));
endmodule

bind rs485_dir_top rs485_dir_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .txBusy(txBusy), .modeEn(modeEn),
  .modePol(modePol), .rtsOut(rtsOut), .divisor(divisor),
  .modeRdData(modeRdData)
);

// File: tb/rs485_dir_top_tb.sv
module rs485_dir_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] modeRdData;
  logic [15:0] divisor = 16'd2;
  logic overSample13 = 1'b0;
  logic txFifoEmpty = 1'b1;
  logic txShiftEmpty = 1'b1;
  logic modemRts = 1'b0;
  logic rtsOut;
  int checks = 0;
  int fails = 0;

  always #2 clk = !clk;

  rs485_dir_top u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .modeRdData(modeRdData), .divisor(divisor),
    .overSample13(overSample13), .txFifoEmpty(txFifoEmpty),
    .txShiftEmpty(txShiftEmpty), .modemRts(modemRts), .rtsOut(rtsOut)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeMode(input logic [5:0] addr, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Sends one frame and measures release timing; holdCycles is 3 bit periods
  task automatic sendFrame(input logic pol, input int holdCycles, input string req);
    @(negedge clk);
    check(rtsOut == !pol, "R3 idle level", rtsOut, !pol);
    txFifoEmpty = 1'b0;
    @(posedge clk); #1;
    check(rtsOut == pol, "R4 first edge", rtsOut, pol);
    @(negedge clk);
    txShiftEmpty = 1'b0; txFifoEmpty = 1'b1;
    repeat (8) @(negedge clk);
    check(rtsOut == pol, "R3 sending level", rtsOut, pol);
    txShiftEmpty = 1'b1;
    @(posedge clk);
    if (holdCycles > 1) repeat (holdCycles - 1) @(posedge clk);
    #1;
    check(rtsOut == pol, {req, " held to last cycle"}, rtsOut, pol);
    @(posedge clk); #1;
    check(rtsOut == !pol, {req, " released on time"}, rtsOut, !pol);
  endtask

  task automatic testReset();
    check(modeRdData == 8'h00, "R1 mode reset", modeRdData, 0);
    @(negedge clk); modemRts = 1'b1; #1;
    check(rtsOut == 1'b1, "R1 follows modem", rtsOut, 1);
    @(negedge clk); modemRts = 1'b0; #1;
    check(rtsOut == 1'b0, "R1 follows modem", rtsOut, 0);
  endtask

  task automatic testDisabled();
    @(negedge clk); modemRts = 1'b1; txFifoEmpty = 1'b0;
    repeat (3) @(negedge clk);
    check(rtsOut == 1'b1, "R2 disabled busy high", rtsOut, 1);
    modemRts = 1'b0;
    @(negedge clk);
    check(rtsOut == 1'b0, "R2 disabled busy low", rtsOut, 0);
    txFifoEmpty = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testAddr();
    writeMode(6'h21, 8'h18);
    check(modeRdData == 8'h00, "R10 other offset ignored", modeRdData, 0);
    writeMode(6'h20, 8'hFF);
    check(modeRdData == 8'h18, "R10 bits 4 and 3 only", modeRdData, 8'h18);
  endtask

  task automatic testCancel();
    int p = 32;
    @(negedge clk); txShiftEmpty = 1'b0;
    repeat (4) @(negedge clk);
    txShiftEmpty = 1'b1;
    repeat (p) begin
      @(posedge clk); #1;
      check(rtsOut == 1'b1, "R7 held before restart", rtsOut, 1);
    end
    @(negedge clk); txShiftEmpty = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      if (rtsOut != 1'b1) check(1'b0, "R7 no gap after restart", rtsOut, 1);
    end
    check(rtsOut == 1'b1, "R7 still asserted", rtsOut, 1);
    @(negedge clk); txShiftEmpty = 1'b1;
    @(posedge clk);
    repeat (3 * p - 1) @(posedge clk);
    #1; check(rtsOut == 1'b1, "R7 fresh hold last cycle", rtsOut, 1);
    @(posedge clk); #1;
    check(rtsOut == 1'b0, "R7 fresh hold release", rtsOut, 0);
  endtask

  task automatic testZeroDiv();
    @(negedge clk); divisor = 16'd0; txShiftEmpty = 1'b0;
    @(posedge clk); #1;
    check(rtsOut == 1'b1, "R8 asserted", rtsOut, 1);
    @(negedge clk); txShiftEmpty = 1'b1;
    @(posedge clk); #1;
    check(rtsOut == 1'b0, "R8 immediate release", rtsOut, 0);
    @(negedge clk); divisor = 16'd2;
  endtask

  task automatic testDeferred();
    @(negedge clk); txShiftEmpty = 1'b0; modemRts = 1'b1;
    writeMode(6'h20, 8'h00);
    check(modeRdData == 8'h18, "R9 write deferred in frame", modeRdData, 8'h18);
    check(rtsOut == 1'b1, "R9 output unchanged", rtsOut, 1);
    txShiftEmpty = 1'b1;
    @(posedge clk);
    repeat (3 * 32 - 1) @(posedge clk);
    #1; check(modeRdData == 8'h18, "R9 deferred through hold", modeRdData, 8'h18);
    check(rtsOut == 1'b1, "R9 hold unaffected", rtsOut, 1);
    @(posedge clk); @(posedge clk); #1;
    check(modeRdData == 8'h00, "R9 applied at idle", modeRdData, 0);
    check(rtsOut == 1'b1, "R9 now follows modem", rtsOut, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testAddr();
    divisor = 16'd2; overSample13 = 1'b0;
    sendFrame(1'b1, 3 * 16 * 2, "R5 16x div2");
    @(negedge clk); divisor = 16'd3; overSample13 = 1'b1;
    sendFrame(1'b1, 3 * 13 * 3, "R6 13x div3");
    @(negedge clk); divisor = 16'd2; overSample13 = 1'b0;
    testCancel();
    testZeroDiv();
    writeMode(6'h20, 8'h10);
    check(modeRdData == 8'h10, "R10 enable only", modeRdData, 8'h10);
    sendFrame(1'b0, 3 * 16 * 2, "R5 active-low");
    writeMode(6'h20, 8'h18);
    testDeferred();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule